// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs the external bus cycles of a small controller whose address space is split into three external regions: a general external area, a 256-kbyte expansion window and a card expansion window. A master presents an address, a read/write flag and a request. The block finds the region the address falls in and times the access with that region's settings. It drives a read or write strobe and returns a one-clock done pulse when the access is over.

Each region keeps its own settings. An access is either 2-state (T1, T2) or 3-state (T1, T2, any wait states Tw, then T3). A 3-state access can insert program wait states. In wait mode 1 it can also stretch further on an external wait input. The card window has a memory-card option that switches to a 3-bit wait code reaching up to ten waits. Each bus state lasts two clocks, so the strobe can start halfway through T1. Settings are written over a small register port. Every access uses the settings captured when it is accepted, so a write never alters an access already under way.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: An access to a 2-state region lasts exactly 4 clocks (T1 and T2, two clocks each). It inserts no wait state and ignores waitIn.
- R2: In the general area (address bits [23:22] = 01), a 3-state access with wait count n (0 to 3) lasts 2*(3+n) clocks when no extra waits are added.
- R3: The expansion window (address bits [23:18] = 001000) uses its own 2-state/3-state bit, wait mode and 2-bit wait count, independent of the general area.
- R4: The card window (address bits [23:20] = 0011) uses only the low two bits of its 3-bit code in normal mode (0 to 3 waits). In memory-card mode, codes 0 to 7 give 0, 1, 2, 3, 4, 6, 8 and 10 waits.
- R5: In wait mode 1, a 3-state access samples waitIn at the end of the last program wait state, or at the end of T2 when the wait count is zero. It adds one more Tw for each consecutive high sample. In wait mode 0, waitIn has no effect.
- R6: The strobe is low in the first clock of T1 and high from the second clock of T1 through the last clock of the access. rdStrobe is used for reads and wrStrobe for writes, and the two are never high together.
- R7: done is high for exactly one clock, which is the last clock of the access.
- R8: Decode gives priority to the card window, then the expansion window, then the general area. Any other address runs as a 2-state access with no waits.
- R9: Register select 0 addresses the general area and select 1 the expansion window. Both use the layout bit0 = 3-state, bit1 = wait mode, bits[3:2] = wait count. Select 2 addresses the card window with the layout bit0 = 3-state, bit1 = wait mode, bit2 = memory-card mode, bits[5:3] = code. Select 3 writes are ignored. After reset, every region is 3-state, wait mode 0, with code/count 3.
- R10: A register write changes only accesses accepted after the clock of the write. A write in the same clock as an acceptance, or during an access, leaves that access unchanged.
- R11: While no access is in progress, rdStrobe, wrStrobe and done stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write enable |
| cfgSel | input | 2 | Register select |
| cfgWdata | input | 8 | Register write data |
| reqValid | input | 1 | Access request, held until done |
| reqAddr | input | 24 | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| waitIn | input | 1 | External wait request |
| rdStrobe | output | 1 | Read strobe |
| wrStrobe | output | 1 | Write strobe |
| done | output | 1 | One-clock completion pulse |

## Verification
Two events can land on the same clock: a register write and the acceptance of a new access. The bench provokes this by asserting cfgWe and reqValid on the same edge, with new data that changes the target region's wait count. It judges the result by requiring that this access run with the old length and the following access with the new one. A second case writes in the middle of an access and applies the same rule. Randomised accesses also check, clock by clock, that wait-mode extension and program waits add up without overlap.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  localparam int WAIT_W    = 4;
  localparam int MAX_WAITS = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3
  } busState_t;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_GEN,
    RGN_EXP,
    RGN_CARD
  } region_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic decWait;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic threeState;
    logic waitMode;
    logic waitZero;
    logic isWrite;
  } dpStatus_t;

  typedef struct packed {
    logic       threeState;
    logic       waitMode;
    logic [1:0] waitCount;
  } stdCfg_t;

  typedef struct packed {
    logic       threeState;
    logic       waitMode;
    logic       cardMode;
    logic [2:0] waitCode;
  } cardCfg_t;

  // memory-card code: 0..4 linear, then steps of two up to ten
  function automatic logic [WAIT_W-1:0] cardWaits(input logic [2:0] code);
    logic [WAIT_W-1:0] c;
    c = WAIT_W'(code);
    if (code <= 3'd4) return c;
    return WAIT_W'((c - WAIT_W'(2)) << 1);
  endfunction

endpackage

// File: rtl/ewc_decode.sv
module ewc_decode
  import ewc_pkg::*;
#(
  parameter int AW         = 24,
  parameter int GEN_SHIFT  = 22,
  parameter int GEN_BASE   = 1,
  parameter int EXP_BASE   = 8,
  parameter int CARD_SHIFT = 20,
  parameter int CARD_BASE  = 3
) (
  input  logic [AW-1:0] addr,
  output region_t       region
);

  localparam int EXP_SHIFT = 18;  // 256-kbyte window

  logic hitGen, hitExp, hitCard;

  always_comb begin
    hitGen  = (addr >> GEN_SHIFT)  == AW'(GEN_BASE);
    hitExp  = (addr >> EXP_SHIFT)  == AW'(EXP_BASE);
    hitCard = (addr >> CARD_SHIFT) == AW'(CARD_BASE);
    if (hitCard)      region = RGN_CARD;
    else if (hitExp)  region = RGN_EXP;
    else if (hitGen)  region = RGN_GEN;
    else              region = RGN_NONE;
  end

endmodule

// File: rtl/ewc_datapath.sv
module ewc_datapath
  import ewc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic [7:0] cfgWdata,
  input  region_t    region,
  input  logic       reqWrite,
  input  ctlStrobe_t ctl,
  output dpStatus_t  status
);

  stdCfg_t  genCfg, expCfg;
  cardCfg_t cardCfg;

  logic              effThree, effMode;
  logic [WAIT_W-1:0] effWaits;

  logic              snapThree, snapMode, snapWrite;
  logic [WAIT_W-1:0] waitLeft;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      genCfg.threeState  <= 1'b1;
      genCfg.waitMode    <= 1'b0;
      genCfg.waitCount   <= 2'd3;
      expCfg.threeState  <= 1'b1;
      expCfg.waitMode    <= 1'b0;
      expCfg.waitCount   <= 2'd3;
      cardCfg.threeState <= 1'b1;
      cardCfg.waitMode   <= 1'b0;
      cardCfg.cardMode   <= 1'b0;
      cardCfg.waitCode   <= 3'd3;
    end else if (cfgWe) begin
      case (cfgSel)
        2'd0: begin
          genCfg.threeState <= cfgWdata[0];
          genCfg.waitMode   <= cfgWdata[1];
          genCfg.waitCount  <= cfgWdata[3:2];
        end
        2'd1: begin
          expCfg.threeState <= cfgWdata[0];
          expCfg.waitMode   <= cfgWdata[1];
          expCfg.waitCount  <= cfgWdata[3:2];
        end
        2'd2: begin
          cardCfg.threeState <= cfgWdata[0];
          cardCfg.waitMode   <= cfgWdata[1];
          cardCfg.cardMode   <= cfgWdata[2];
          cardCfg.waitCode   <= cfgWdata[5:3];
        end
        default: ;
      endcase
    end
  end

  // settings of the decoded region
  always_comb begin
    effThree = 1'b0;
    effMode  = 1'b0;
    effWaits = '0;
    case (region)
      RGN_GEN: begin
        effThree = genCfg.threeState;
        effMode  = genCfg.waitMode;
        effWaits = WAIT_W'(genCfg.waitCount);
      end
      RGN_EXP: begin
        effThree = expCfg.threeState;
        effMode  = expCfg.waitMode;
        effWaits = WAIT_W'(expCfg.waitCount);
      end
      RGN_CARD: begin
        effThree = cardCfg.threeState;
        effMode  = cardCfg.waitMode;
        effWaits = cardCfg.cardMode ? cardWaits(cardCfg.waitCode)
                                    : WAIT_W'(cardCfg.waitCode[1:0]);
      end
      default: ;
    endcase
    if (!effThree) begin
      effMode  = 1'b0;
      effWaits = '0;
    end
  end

  // per-access snapshot and wait counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapThree <= 1'b0;
      snapMode  <= 1'b0;
      snapWrite <= 1'b0;
      waitLeft  <= '0;
    end else if (ctl.accept) begin
      snapThree <= effThree;
      snapMode  <= effMode;
      snapWrite <= reqWrite;
      waitLeft  <= effWaits;
    end else if (ctl.decWait) begin
      waitLeft  <= waitLeft - WAIT_W'(1);
    end
  end

  always_comb begin
    status.threeState = snapThree;
    status.waitMode   = snapMode;
    status.waitZero   = (waitLeft == '0);
    status.isWrite    = snapWrite;
  end

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decWait |-> waitLeft != '0);

  assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    waitLeft <= WAIT_W'(MAX_WAITS));

endmodule

// File: rtl/ewc_control.sv
module ewc_control
  import ewc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       waitIn,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       rdStrobe,
  output logic       wrStrobe,
  output logic       done
);

  busState_t state, stateNext;
  logic      phase, phaseNext;
  logic      strobe;

  // decision at the end of T2 or a Tw in a 3-state access
  function automatic busState_t afterWait(input dpStatus_t s, input logic w);
    if (!s.waitZero)          return ST_TW;
    if (s.waitMode && w)      return ST_TW;
    return ST_T3;
  endfunction

  always_comb begin
    stateNext   = state;
    phaseNext   = phase;
    ctl.accept  = 1'b0;
    ctl.decWait = 1'b0;
    if (state == ST_IDLE) begin
      if (reqValid) begin
        ctl.accept = 1'b1;
        stateNext  = ST_T1;
        phaseNext  = 1'b0;
      end
    end else if (!phase) begin
      phaseNext = 1'b1;
    end else begin
      phaseNext = 1'b0;
      case (state)
        ST_T1: stateNext = ST_T2;
        ST_T2, ST_TW: begin
          if (state == ST_T2 && !status.threeState) begin
            stateNext = ST_IDLE;
          end else begin
            stateNext   = afterWait(status, waitIn);
            ctl.decWait = !status.waitZero;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  always_comb begin
    strobe   = (state == ST_T1 && phase) || state == ST_T2 ||
               state == ST_TW || state == ST_T3;
    done     = phase && ((state == ST_T2 && !status.threeState) ||
                         state == ST_T3);
    rdStrobe = strobe && !status.isWrite;
    wrStrobe = strobe && status.isWrite;
  end

  assert_tw_three_R1: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_TW |-> status.threeState);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe || wrStrobe) && !done |=> (rdStrobe || wrStrobe));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !rdStrobe && !wrStrobe && !done);

endmodule

// File: rtl/ext_bus_wait_ctrl.sv
module ext_bus_wait_ctrl
  import ewc_pkg::*;
#(
  parameter int AW         = 24,
  parameter int GEN_SHIFT  = 22,
  parameter int GEN_BASE   = 1,
  parameter int EXP_BASE   = 8,
  parameter int CARD_SHIFT = 20,
  parameter int CARD_BASE  = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [7:0]    cfgWdata,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqWrite,
  input  logic          waitIn,
  output logic          rdStrobe,
  output logic          wrStrobe,
  output logic          done
);

  region_t    region;
  ctlStrobe_t ctl;
  dpStatus_t  status;

  ewc_decode #(
    .AW(AW), .GEN_SHIFT(GEN_SHIFT), .GEN_BASE(GEN_BASE),
    .EXP_BASE(EXP_BASE), .CARD_SHIFT(CARD_SHIFT), .CARD_BASE(CARD_BASE)
  ) u_decode (
    .addr   (reqAddr),
    .region (region)
  );

  ewc_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .region   (region),
    .reqWrite (reqWrite),
    .ctl      (ctl),
    .status   (status)
  );

  ewc_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .waitIn   (waitIn),
    .status   (status),
    .ctl      (ctl),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .done     (done)
  );

endmodule

// File: tb/ext_bus_wait_ctrl_tb.sv
module ext_bus_wait_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [7:0]  cfgWdata = '0;
  logic        reqValid = 1'b0;
  logic [23:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        waitIn = 1'b0;
  logic        rdStrobe, wrStrobe, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model of the settings
  bit       mGen3 = 1, mGenMode = 0;  bit [1:0] mGenCnt = 3;
  bit       mExp3 = 1, mExpMode = 0;  bit [1:0] mExpCnt = 3;
  bit       mCard3 = 1, mCardMode = 0, mCardMem = 0; bit [2:0] mCardCode = 3;

  always #10 clk = ~clk;

  ext_bus_wait_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .waitIn(waitIn),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void applyCfg(input bit [1:0] sel, input bit [7:0] d);
    case (sel)
      2'd0: begin mGen3 = d[0]; mGenMode = d[1]; mGenCnt = d[3:2]; end
      2'd1: begin mExp3 = d[0]; mExpMode = d[1]; mExpCnt = d[3:2]; end
      2'd2: begin mCard3 = d[0]; mCardMode = d[1]; mCardMem = d[2]; mCardCode = d[5:3]; end
      default: ;
    endcase
  endfunction

  function automatic int memCardWaits(input bit [2:0] c);
    case (c)
      3'd5: return 6;
      3'd6: return 8;
      3'd7: return 10;
      default: return int'(c);
    endcase
  endfunction

  function automatic void expSettings(input bit [23:0] a, output bit three,
                                      output bit mode, output int n);
    three = 0; mode = 0; n = 0;
    if (a[23:20] == 4'h3) begin
      three = mCard3; mode = mCardMode;
      n = mCardMem ? memCardWaits(mCardCode) : int'(mCardCode[1:0]);
    end else if (a[23:18] == 6'h08) begin
      three = mExp3; mode = mExpMode; n = int'(mExpCnt);
    end else if (a[23:22] == 2'b01) begin
      three = mGen3; mode = mGenMode; n = int'(mGenCnt);
    end
    if (!three) begin mode = 0; n = 0; end
  endfunction

  task automatic cfgWrite(input bit [1:0] sel, input bit [7:0] d);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 0;
    applyCfg(sel, d);
  endtask

  // cfgWhen: 0 none, 1 same clock as acceptance, 2 in the middle of the access
  task automatic runCycle(input bit [23:0] a, input bit wr, input int extra,
                          input int cfgWhen, input bit [1:0] sel,
                          input bit [7:0] d, input string tag);
    bit three, mode;
    int n, expTotal, thr, c, strobes, wrongType;
    bit sawDone, firstLow;
    expSettings(a, three, mode, n);
    expTotal = !three ? 4 : 2 * (3 + n + (mode ? extra : 0));
    thr = 3 + 2 * n + 2 * extra;
    @(negedge clk);
    reqAddr = a; reqWrite = wr; reqValid = 1;
    if (cfgWhen == 1) begin cfgWe = 1; cfgSel = sel; cfgWdata = d; end
    c = 0; strobes = 0; wrongType = 0; sawDone = 0; firstLow = 1;
    while (!sawDone && c < 100) begin
      @(negedge clk);
      if (cfgWhen == 1 && c == 0) cfgWe = 0;
      if (cfgWhen == 2 && c == 2) begin cfgWe = 1; cfgSel = sel; cfgWdata = d; end
      if (cfgWhen == 2 && c == 3) cfgWe = 0;
      if (rdStrobe || wrStrobe) strobes++;
      if (c == 0 && (rdStrobe || wrStrobe)) firstLow = 0;
      if ((wr && rdStrobe) || (!wr && wrStrobe)) wrongType++;
      if (three && mode && (c % 2 == 1) && c >= 3 + 2 * n)
        waitIn = (c < thr);
      else
        waitIn = $urandom_range(0, 1);
      c++;
      if (done) begin sawDone = 1; reqValid = 0; end
    end
    if (cfgWhen != 0) applyCfg(sel, d);
    chk(sawDone && c == expTotal, tag, "access length", c, expTotal);
    chk(strobes == expTotal - 1 && firstLow, "R6", "strobe clocks", strobes, expTotal - 1);
    chk(wrongType == 0, "R6", "wrong strobe type clocks", wrongType, 0);
    @(negedge clk);
    chk(!done, "R7", "done after access", int'(done), 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!rdStrobe && !wrStrobe && !done, "R9", "outputs after reset",
        int'({rdStrobe, wrStrobe, done}), 0);

    // reset defaults: 3-state, 3 waits
    runCycle(24'h400010, 0, 0, 0, 0, 0, "R9");
    runCycle(24'h210000, 1, 0, 0, 0, 0, "R9");
    runCycle(24'h300000, 0, 0, 0, 0, 0, "R9");

    // R11: idle is quiet
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!rdStrobe && !wrStrobe && !done, "R11", "idle outputs",
          int'({rdStrobe, wrStrobe, done}), 0);
    end

    // R1: 2-state general, waitIn random
    cfgWrite(0, 8'h00);
    runCycle(24'h400000, 0, 2, 0, 0, 0, "R1");
    runCycle(24'h7FFFFF, 1, 0, 0, 0, 0, "R1");

    // R2: each wait count
    for (int k = 0; k < 4; k++) begin
      cfgWrite(0, 8'((k << 2) | 1));
      runCycle(24'h412345, k[0], 0, 0, 0, 0, "R2");
    end

    // R3: independence of expansion window
    cfgWrite(1, 8'h00);
    cfgWrite(0, 8'h0D);
    runCycle(24'h23FFFF, 0, 0, 0, 0, 0, "R3");
    runCycle(24'h400000, 0, 0, 0, 0, 0, "R3");
    cfgWrite(1, 8'h09);
    runCycle(24'h200000, 1, 0, 0, 0, 0, "R3");

    // R4: card normal uses low two bits; memory-card codes
    cfgWrite(2, 8'h39);
    runCycle(24'h3ABCDE, 0, 0, 0, 0, 0, "R4");
    for (int k = 0; k < 8; k++) begin
      cfgWrite(2, 8'((k << 3) | 5));
      runCycle(24'h300004, 0, 0, 0, 0, 0, "R4");
    end

    // R5: wait mode 1 extends, mode 0 ignores
    cfgWrite(0, 8'h03);
    runCycle(24'h400000, 0, 2, 0, 0, 0, "R5");
    cfgWrite(0, 8'h0F);
    runCycle(24'h400000, 1, 3, 0, 0, 0, "R5");
    cfgWrite(2, 8'h3F);
    runCycle(24'h300000, 0, 1, 0, 0, 0, "R5");
    cfgWrite(0, 8'h0D);
    runCycle(24'h400000, 0, 3, 0, 0, 0, "R5");

    // R8: decode priority and unmapped addresses
    runCycle(24'h000100, 0, 0, 0, 0, 0, "R8");
    runCycle(24'h240000, 1, 0, 0, 0, 0, "R8");
    runCycle(24'h800000, 0, 0, 0, 0, 0, "R8");
    runCycle(24'hFFFFFF, 0, 0, 0, 0, 0, "R8");

    // R9: select 3 ignored
    cfgWrite(3, 8'h00);
    runCycle(24'h400000, 0, 0, 0, 0, 0, "R9");
    runCycle(24'h220000, 0, 0, 0, 0, 0, "R9");
    runCycle(24'h300000, 0, 0, 0, 0, 0, "R9");

    // R10: write with acceptance, then mid-access
    cfgWrite(0, 8'h0D);
    runCycle(24'h400000, 0, 0, 1, 0, 8'h01, "R10");
    runCycle(24'h400000, 0, 0, 0, 0, 0, "R10");
    runCycle(24'h400000, 1, 0, 2, 0, 8'h09, "R10");
    runCycle(24'h400000, 1, 0, 0, 0, 0, "R10");

    // random mix
    for (int i = 0; i < 60; i++) begin
      bit [23:0] a;
      int pick;
      pick = $urandom_range(0, 3);
      a = 24'($urandom);
      case (pick)
        0: a[23:22] = 2'b01;
        1: a[23:18] = 6'h08;
        2: a[23:20] = 4'h3;
        default: a[23:20] = 4'h9;
      endcase
      if ($urandom_range(0, 2) == 0)
        cfgWrite(2'($urandom_range(0, 3)), 8'($urandom));
      runCycle(a, 1'($urandom_range(0, 1)), $urandom_range(0, 3),
               ($urandom_range(0, 5) == 0) ? 1 : 0,
               2'($urandom_range(0, 2)), 8'($urandom),
               pick == 3 ? "R8" : "R2");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule